// File: doc/BRIEF.md
# Multi-Region SRAM Bus Cycle Generator

This block turns requests from an internal master into external bus cycles for static-memory regions. It decodes the top three bits of a 29-bit request address to pick one of two regions. For the chosen region it drives an active-low chip select, a read strobe that can also serve as output enable, and four active-low byte-lane write strobes.

Every region has its own timing configuration. An optional setup cycle separates address and chip-select valid from the strobe. A 3-bit code selects a programmed number of wait cycles. After the programmed waits run out, an active-low external ready pin can stretch the strobe without limit. A hold of zero to three cycles keeps chip select and address valid after the strobe ends. Each region also has a data width setting, and the write strobes are limited to the byte lanes that this width and the low address bits cover.

The master uses a valid/ready handshake. It holds the request stable until ready. Ready is returned in the last strobe cycle, and read data is registered on that same edge. An address that decodes to neither region is answered at once with an error flag, and no bus cycle takes place.

Top module: `sram_cycle_gen`

## Requirements
- R1: Address bits 28:26 equal to 3'b000 select region 0 and drive `bus_cs_n[0]` low. 3'b001 selects region 1 and drives `bus_cs_n[1]` low. At most one chip select is low at any time, and it stays low from the setup phase through the last hold cycle.
- R2: A valid request whose bits 28:26 are 2 through 7 gets `req_ready` and `rsp_err` high in the same cycle while the block is idle. No chip select or strobe is asserted for it.
- R3: During the strobe phase, a read drives `bus_rd_n` low with all `bus_we_n` high. A write drives `bus_rd_n` high. The two strobe kinds never overlap.
- R4: The strobe phase lasts 1 + W + E cycles. W comes from the region's wait code: codes 0, 1, 2 and 3 give W equal to the code, and codes 4, 5, 6 and 7 give W = 6, 9, 12 and 15. E is the number of extra waits from R5.
- R5: `bus_rdy_n` is ignored while programmed waits remain. Once they are used up, every strobe cycle with `bus_rdy_n` high adds one more strobe cycle.
- R6: With the region's setup bit at 1, chip select and address are valid for exactly one cycle before the strobe. With the setup bit at 0, they assert in the same cycle as the strobe.
- R7: After the strobe ends, chip select stays low for exactly the region's 2-bit hold value (0 to 3 cycles) with no strobe active. Then all chip selects go high.
- R8: Width code 0 (8-bit) enables lane `addr[1:0]`. Width code 1 (16-bit) enables lanes 1:0 when `addr[1]` is 0 and lanes 3:2 otherwise. Width codes 2 and 3 (32-bit) enable all four lanes. In a write, `bus_we_n` is low exactly on the enabled lanes.
- R9: For a decoded request, `req_ready` is high only in the last strobe cycle, with `rsp_err` low. For a read, `rsp_rdata` holds the `bus_rdata` value of that cycle from the next cycle on. Timing and width come from the configuration of the addressed region only. During the strobe, `bus_addr` and `bus_wdata` equal the request's address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request complete (handshake) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 29 | Request byte address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| rsp_err | output | 1 | Request addressed no region |
| r0_wait | input | 3 | Region 0 wait code |
| r0_setup | input | 1 | Region 0 setup cycle enable |
| r0_hold | input | 2 | Region 0 hold cycles |
| r0_width | input | 2 | Region 0 width code |
| r1_wait | input | 3 | Region 1 wait code |
| r1_setup | input | 1 | Region 1 setup cycle enable |
| r1_hold | input | 2 | Region 1 hold cycles |
| r1_width | input | 2 | Region 1 width code |
| bus_addr | output | 29 | External address |
| bus_cs_n | output | 2 | Active-low chip selects, one per region |
| bus_rd_n | output | 1 | Active-low read strobe / output enable |
| bus_we_n | output | 4 | Active-low byte-lane write strobes |
| bus_wdata | output | 32 | External write data |
| bus_rdata | input | 32 | External read data |
| bus_rdy_n | input | 1 | Active-low external ready |

## Verification
The hardest case to reach is the point where the programmed wait count has just run out and the external ready pin takes over. Stalls there must extend the strobe by exactly one cycle each, and the handshake must move along with them. This matters most with zero programmed waits or a zero hold, where the last strobe cycle runs straight into idle. The bench counts the strobe cycles it has seen in the current access. At each falling edge it drives the ready pin high until that count reaches the programmed waits plus a chosen number of extra stalls. This covers every wait code, setup and hold combination, in both regions and both directions, with several stall lengths.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  localparam int LANES   = 4;
  localparam int NUM_RGN = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } phase_e;

  typedef struct packed {
    logic [2:0] wait_code;
    logic       setup;
    logic [1:0] hold;
    logic [1:0] width;
  } rgn_cfg_t;

  // programmed wait cycles for a 3-bit code: linear to 3, then steps of 3
  function automatic logic [3:0] wait_cycles(input logic [2:0] code);
    int n;
    if (code < 3'd4) n = int'(code);
    else             n = 3 * (int'(code) - 2);
    return 4'(n);
  endfunction

  // is byte lane 'lane' covered by an access of this width at offset 'off'
  function automatic logic lane_hit(input logic [1:0] width,
                                    input logic [1:0] off,
                                    input logic [1:0] lane);
    case (width)
      2'd0:    return off == lane;
      2'd1:    return off[1] == lane[1];
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/sramc_decode.sv
module sramc_decode #(
  parameter int ADDR_W  = 29,
  parameter int SEL_W   = 3,
  parameter int NUM_RGN = 2,
  localparam int IDX_W  = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_RGN-1:0] hit_vec,
  output logic               hit_any,
  output logic [IDX_W-1:0]   rgn_idx
);

  logic [SEL_W-1:0] sel;
  assign sel = addr[ADDR_W-1 -: SEL_W];

  for (genvar i = 0; i < NUM_RGN; i++) begin : g_rgn
    assign hit_vec[i] = (sel == SEL_W'(i));
  end

  assign hit_any = |hit_vec;
  assign rgn_idx = sel[IDX_W-1:0];

endmodule

// File: rtl/sramc_lanes.sv
module sramc_lanes
  import sramc_pkg::*;
#(
  parameter int NLANE = LANES
) (
  input  logic [1:0]       width,
  input  logic [1:0]       off,
  output logic [NLANE-1:0] mask
);

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    assign mask[l] = lane_hit(width, off, 2'(l));
  end

endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
  import sramc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       setup_en,
  input  logic [3:0] wait_init,
  input  logic [1:0] hold_init,
  input  logic       rdy_n,
  output phase_e     phase,
  output logic       strobe_on,
  output logic       cs_on,
  output logic       last_strobe
);

  logic [3:0] wcnt;
  logic [1:0] hcnt;
  logic       wait_done;

  assign wait_done   = (wcnt == 4'd0);
  assign strobe_on   = (phase == ST_STROBE);
  assign cs_on       = (phase != ST_IDLE);
  assign last_strobe = strobe_on && wait_done && !rdy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= ST_IDLE;
      wcnt  <= '0;
      hcnt  <= '0;
    end else begin
      case (phase)
        ST_IDLE: if (start) begin
          phase <= setup_en ? ST_SETUP : ST_STROBE;
          wcnt  <= wait_init;
          hcnt  <= hold_init;
        end
        ST_SETUP: phase <= ST_STROBE;
        ST_STROBE: begin
          if (!wait_done)  wcnt  <= wcnt - 4'd1;
          else if (!rdy_n) phase <= (hcnt != 2'd0) ? ST_HOLD : ST_IDLE;
        end
        ST_HOLD: begin
          if (hcnt == 2'd1) phase <= ST_IDLE;
          else              hcnt  <= hcnt - 2'd1;
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  // R4
  wait_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_STROBE && wcnt != 4'd0) |=>
      (phase == ST_STROBE && wcnt == 4'($past(wcnt) - 4'd1)));

  // R5
  rdy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_STROBE && wait_done && rdy_n) |=> (phase == ST_STROBE));

  // R6
  setup_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_SETUP) |=> (phase == ST_STROBE));

  // R7
  hold_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_HOLD && hcnt != 2'd1) |=> (phase == ST_HOLD));

endmodule

// File: rtl/sram_cycle_gen.sv
module sram_cycle_gen
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 29,
  parameter int DATA_W = 8 * LANES,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  input  logic [2:0]        r0_wait,
  input  logic              r0_setup,
  input  logic [1:0]        r0_hold,
  input  logic [1:0]        r0_width,
  input  logic [2:0]        r1_wait,
  input  logic              r1_setup,
  input  logic [1:0]        r1_hold,
  input  logic [1:0]        r1_width,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [NUM_RGN-1:0] bus_cs_n,
  output logic              bus_rd_n,
  output logic [LANES-1:0]  bus_we_n,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_rdy_n
);

  localparam int IDX_W = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1;

  // per-region configuration, gathered into one array
  rgn_cfg_t cfg_arr [NUM_RGN];
  assign cfg_arr[0] = '{wait_code: r0_wait, setup: r0_setup, hold: r0_hold, width: r0_width};
  assign cfg_arr[1] = '{wait_code: r1_wait, setup: r1_setup, hold: r1_hold, width: r1_width};

  logic [NUM_RGN-1:0] hit_vec;
  logic               hit_any;
  logic [IDX_W-1:0]   rgn_idx;
  rgn_cfg_t           cfg_sel;
  logic [LANES-1:0]   lane_mask;

  sramc_decode #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .NUM_RGN(NUM_RGN)) u_decode (
    .addr    (req_addr),
    .hit_vec (hit_vec),
    .hit_any (hit_any),
    .rgn_idx (rgn_idx)
  );

  assign cfg_sel = cfg_arr[rgn_idx];

  sramc_lanes #(.NLANE(LANES)) u_lanes (
    .width (cfg_sel.width),
    .off   (req_addr[1:0]),
    .mask  (lane_mask)
  );

  // named events
  phase_e phase;
  logic   idle, start, err_now, strobe_on, cs_on, last_strobe;

  assign idle    = (phase == ST_IDLE);
  assign start   = idle && req_valid && hit_any;
  assign err_now = idle && req_valid && !hit_any;

  sramc_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .setup_en    (cfg_sel.setup),
    .wait_init   (wait_cycles(cfg_sel.wait_code)),
    .hold_init   (cfg_sel.hold),
    .rdy_n       (bus_rdy_n),
    .phase       (phase),
    .strobe_on   (strobe_on),
    .cs_on       (cs_on),
    .last_strobe (last_strobe)
  );

  // access context, latched on acceptance
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               wr_q;
  logic [NUM_RGN-1:0] rgn_q;
  logic [LANES-1:0]   mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      wdata_q   <= '0;
      wr_q      <= 1'b0;
      rgn_q     <= '0;
      mask_q    <= '0;
      rsp_rdata <= '0;
    end else begin
      if (start) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        wr_q    <= req_write;
        rgn_q   <= hit_vec;
        mask_q  <= lane_mask;
      end
      if (last_strobe && !wr_q) rsp_rdata <= bus_rdata;
    end
  end

  logic rd_act, we_act;
  assign rd_act = strobe_on && !wr_q;
  assign we_act = strobe_on && wr_q;

  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign bus_cs_n  = ~(cs_on ? rgn_q : '0);
  assign bus_rd_n  = ~rd_act;
  assign bus_we_n  = ~(we_act ? mask_q : '0);
  assign req_ready = last_strobe || err_now;
  assign rsp_err   = err_now;

  // R1
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && bus_we_n != '1));

  // R2
  err_nocs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (req_ready && bus_cs_n == '1 && bus_rd_n));

  // R9
  ready_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !rsp_err) |-> (!bus_rd_n || bus_we_n != '1));

  // R7
  strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || bus_we_n != '1) |-> (bus_cs_n != '1));

endmodule

// File: tb/sram_cycle_gen_bench.sv
module sram_cycle_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [28:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_err;
  logic [31:0] rsp_rdata;
  logic [2:0]  r0_wait = '0, r1_wait = '0;
  logic        r0_setup = 1'b0, r1_setup = 1'b0;
  logic [1:0]  r0_hold = '0, r1_hold = '0, r0_width = 2'd2, r1_width = 2'd2;
  logic [28:0] bus_addr;
  logic [1:0]  bus_cs_n;
  logic        bus_rd_n;
  logic [3:0]  bus_we_n;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        bus_rdy_n = 1'b1;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  sram_cycle_gen u_sram_cycle_gen (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .r0_wait(r0_wait), .r0_setup(r0_setup), .r0_hold(r0_hold), .r0_width(r0_width),
    .r1_wait(r1_wait), .r1_setup(r1_setup), .r1_hold(r1_hold), .r1_width(r1_width),
    .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_we_n(bus_we_n), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdy_n(bus_rdy_n)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_waits(input int code);
    int t [8] = '{0, 1, 2, 3, 6, 9, 12, 15};
    return t[code];
  endfunction

  function automatic logic [3:0] exp_mask(input int wd, input int off);
    if (wd == 0) return 4'b0001 << off;
    if (wd == 1) return (off >= 2) ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  task automatic run_txn(input int r, input bit wr, input int wc, input bit su,
                         input int ho, input int wd, input int off, input int extra);
    logic [28:0] a;
    logic [31:0] wdat, rdat;
    int  w, sidx, setup_n, hold_n, ready_idx;
    bit  got_ready, seen_strobe, strobe, first;
    a    = {3'(r), 24'h5a3c10, 2'(off)};
    wdat = 32'hc0de_0000 ^ {a[15:0], 16'(wc * 37 + ho)};
    rdat = ~wdat ^ 32'(r);
    w    = exp_waits(wc);
    @(negedge clk);
    if (r == 0) begin
      r0_wait = 3'(wc); r0_setup = su; r0_hold = 2'(ho); r0_width = 2'(wd);
      r1_wait = ~3'(wc); r1_setup = ~su; r1_hold = ~2'(ho); r1_width = ~2'(wd);
    end else begin
      r1_wait = 3'(wc); r1_setup = su; r1_hold = 2'(ho); r1_width = 2'(wd);
      r0_wait = ~3'(wc); r0_setup = ~su; r0_hold = ~2'(ho); r0_width = ~2'(wd);
    end
    req_addr = a; req_write = wr; req_wdata = wdat; req_valid = 1'b1;
    bus_rdata = rdat;
    sidx = 0; setup_n = 0; hold_n = 0; ready_idx = -1;
    got_ready = 0; seen_strobe = 0; first = 1;
    #1;
    chk(req_ready == 1'b0 && bus_cs_n == 2'b11, "R9 no ready at accept",
        {req_ready, bus_cs_n}, 3'b011);
    @(posedge clk);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (got_ready) req_valid = 1'b0;
      strobe = (bus_rd_n == 1'b0) || (bus_we_n != 4'hf);
      bus_rdy_n = strobe ? (sidx < w + extra) : 1'b1;
      #1;
      if (bus_cs_n == 2'b11) break;
      if (strobe) begin
        seen_strobe = 1;
        if (first) begin
          first = 0;
          // R1 chip select of the addressed region only
          chk(bus_cs_n == ~(2'b01 << r), "R1 chip select", bus_cs_n, ~(2'b01 << r));
          // R3 / R8 strobe pattern
          chk(bus_rd_n == wr, "R3 read strobe", bus_rd_n, wr);
          chk(bus_we_n == (wr ? ~exp_mask(wd, off) : 4'hf), "R8 write lanes",
              bus_we_n, wr ? ~exp_mask(wd, off) : 4'hf);
          chk(bus_addr == a && (!wr || bus_wdata == wdat), "R9 bus address/data",
              bus_addr, a);
        end
        if (req_ready) begin
          ready_idx = sidx; got_ready = 1;
          chk(rsp_err == 1'b0, "R9 no error on decoded access", rsp_err, 0);
        end
        sidx++;
      end else begin
        if (req_ready) chk(1'b0, "R9 ready outside strobe", 1, 0);
        if (!seen_strobe) setup_n++;
        else              hold_n++;
      end
    end
    req_valid = 1'b0;
    bus_rdy_n = 1'b1;
    // R6 setup
    chk(setup_n == int'(su), "R6 setup cycles", setup_n, su);
    // R4 / R5 strobe length
    chk(sidx == 1 + w + extra, "R4 R5 strobe length", sidx, 1 + w + extra);
    chk(ready_idx == sidx - 1, "R9 ready in last strobe", ready_idx, sidx - 1);
    // R7 hold
    chk(hold_n == ho, "R7 hold cycles", hold_n, ho);
    if (!wr) chk(rsp_rdata == rdat, "R9 read data", rsp_rdata, rdat);
  endtask

  task automatic run_err(input int sel);
    @(negedge clk);
    req_addr = {3'(sel), 26'h0123456}; req_write = 1'b0; req_valid = 1'b1;
    #1;
    // R2
    chk(req_ready && rsp_err, "R2 immediate error", {req_ready, rsp_err}, 2'b11);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(bus_cs_n == 2'b11 && bus_rd_n && bus_we_n == 4'hf, "R2 no bus cycle",
        {bus_cs_n, bus_rd_n, bus_we_n}, 7'h7f);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(bus_cs_n == 2'b11 && bus_rd_n && bus_we_n == 4'hf && !req_ready,
        "R1 reset idle", {bus_cs_n, bus_rd_n, bus_we_n}, 7'h7f);
    rst_n = 1'b1;
    // full timing sweep, 32-bit width
    for (int r = 0; r < 2; r++)
      for (int wr = 0; wr < 2; wr++)
        for (int wc = 0; wc < 8; wc++)
          for (int su = 0; su < 2; su++)
            for (int ho = 0; ho < 4; ho++)
              run_txn(r, 1'(wr), wc, 1'(su), ho, 2, 0, (wc + ho + su) % 3);
    // lane sweep R8
    for (int r = 0; r < 2; r++)
      for (int wd = 0; wd < 4; wd++)
        for (int off = 0; off < 4; off++)
          run_txn(r, 1'b1, 0, 1'b0, 0, wd, off, 0);
    // long external stalls R5
    run_txn(0, 1'b0, 0, 1'b0, 0, 2, 0, 7);
    run_txn(1, 1'b1, 7, 1'b1, 3, 1, 2, 5);
    // undecoded addresses R2
    for (int s = 2; s < 8; s++) run_err(s);
    run_txn(0, 1'b0, 2, 1'b1, 1, 2, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule